// File: doc/BRIEF.md
# Line Concentrator Timeslot Selector

This block gathers the serial PCM groups of a line frame and concentrates them onto one parallel network stream. Eight line units each carry four serial groups, so there are 32 candidate groups. Every group repeats a frame of 24 PCM timeslots. The block turns the bits of each group into parallel words and aligns all groups to one frame sync. It then builds an output frame of 192 network timeslots.

Network slot n can only carry PCM timeslot floor(n/8). Each PCM timeslot therefore has eight network opportunities, and all 32 groups compete for them, which gives a 4:1 concentration. A controller loads a 192-entry selection table. Each entry holds an enable bit and a 5-bit group number. A write that would give two enabled entries in the same block of eight the same group is refused and flagged. The output runs at one network slot per bit clock, trailing the input by one PCM timeslot.

Top module: `lcs_concentrator`

## Requirements
- R1: After reset, net_valid_o and tbl_conflict_o are low and every table entry is disabled. The first frames therefore carry the idle code on all 192 slots.
- R2: Each group in pcm_ser_i carries frames of 24 timeslots of 8 bits, most significant bit first. fsync_i is high in the bit clock that carries the first bit of timeslot 0.
- R3: When entry n is enabled, network slot n carries PCM timeslot floor(n/8) of the group selected by entry n. Group number g is bit g of pcm_ser_i (unit index times four plus the group index within the unit).
- R4: When entry n is disabled, network slot n carries the idle code 8'hD5.
- R5: Network slots leave one per clock on net_data_o, with net_slot_o counting 0 to 191 and wrapping. Slot n appears in the ninth clock after the fsync_i clock, plus n clocks.
- R6: A write with tbl_en_i high is refused, and leaves the table unchanged, when another enabled entry in the same block of eight (entries 8b to 8b+7) already holds the same group.
- R7: tbl_conflict_o is high in exactly the clock after a refused write. It stays low after accepted writes and when no write takes place.
- R8: None of these raises a conflict, and each is accepted: a write with tbl_en_i low; the same group in a different block; rewriting an entry with its own group; matching a group held only by a disabled entry.
- R9: If fsync_i arrives when the frame counter is not at the start of a frame, net_valid_o is low for the next eight clocks. Slot 0 of the new frame then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; high with the first bit of timeslot 0 |
| pcm_ser_i | input | 32 | One serial PCM bit per group |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 8 | Network slot entry to write |
| tbl_en_i | input | 1 | Enable bit for the written entry |
| tbl_sel_i | input | 5 | Group number for the written entry |
| tbl_conflict_o | output | 1 | Pulses the clock after a refused write |
| net_valid_o | output | 1 | Network slot output is valid |
| net_slot_o | output | 8 | Network slot index of net_data_o |
| net_data_o | output | 8 | PCM word of the network slot |

## Verification
The assertions take for granted that fsync_i is a single-clock pulse and that the serial inputs never carry unknown values. They also assume that a deliberate resync is the only case where fsync_i lands away from a frame boundary. The stimulus keeps to this. It drives frames from its own bit position counter, which raises fsync_i once every 192 clocks, and it forces one misaligned pulse only in the resync scenario. Table writes are issued while frames run freely, and each written group number stays inside the 32 available groups.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int unsigned LCS_UNITS        = 8;
  localparam int unsigned LCS_GRP_PER_UNIT = 4;
  localparam int unsigned LCS_PCM_SLOTS    = 24;
  localparam int unsigned LCS_WORD_W       = 8;
  localparam logic [7:0]  LCS_IDLE         = 8'hD5;
  localparam int unsigned LCS_NUM_GRP      = LCS_UNITS * LCS_GRP_PER_UNIT;
  localparam int unsigned LCS_NET_SLOTS    = LCS_PCM_SLOTS * LCS_WORD_W;
endpackage

// File: rtl/lcs_frame_align.sv
module lcs_frame_align #(
  parameter  int unsigned NUM_GRP   = 32,
  parameter  int unsigned WORD_W    = 8,
  parameter  int unsigned PCM_SLOTS = 24,
  localparam int unsigned BIT_W     = $clog2(WORD_W),
  localparam int unsigned PSL_W     = $clog2(PCM_SLOTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fsync_i,
  input  logic [NUM_GRP-1:0]        pcm_ser_i,
  output logic [BIT_W-1:0]          cur_bit_o,
  output logic [PSL_W-1:0]          hold_slot_o,
  output logic [NUM_GRP*WORD_W-1:0] hold_words_o,
  output logic                      slot_vld_o,
  output logic                      frame_pos0_o
);
  logic [BIT_W-1:0] bit_q, cur_bit;
  logic [PSL_W-1:0] slot_q, cur_slot, hold_slot_q;
  logic             synced_q, hold_vld_q;
  logic             realign, last_bit, load;

  always_comb begin
    cur_bit  = fsync_i ? '0 : bit_q;
    cur_slot = fsync_i ? '0 : slot_q;
    realign  = fsync_i && ((bit_q != '0) || (slot_q != '0));
    last_bit = (cur_bit == BIT_W'(WORD_W - 1));
    load     = last_bit && (synced_q || fsync_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q       <= '0;
      slot_q      <= '0;
      synced_q    <= 1'b0;
      hold_vld_q  <= 1'b0;
      hold_slot_q <= '0;
    end else begin
      bit_q <= last_bit ? '0 : cur_bit + 1'b1;
      if (last_bit)
        slot_q <= (cur_slot == PSL_W'(PCM_SLOTS - 1)) ? '0 : cur_slot + 1'b1;
      else
        slot_q <= cur_slot;
      if (fsync_i) synced_q <= 1'b1;
      if (realign)   hold_vld_q <= 1'b0;
      else if (load) hold_vld_q <= 1'b1;
      if (load) hold_slot_q <= cur_slot;
    end
  end

  // one shift register and one holding word per group
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_deser
    logic [WORD_W-2:0] sh_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] nxt;
    assign nxt = {sh_q, pcm_ser_i[g]};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '0;
        word_q <= '0;
      end else begin
        sh_q <= nxt[WORD_W-2:0];
        if (load) word_q <= nxt;
      end
    end
    assign hold_words_o[g*WORD_W +: WORD_W] = word_q;
  end

  assign cur_bit_o    = cur_bit;
  assign hold_slot_o  = hold_slot_q;
  assign slot_vld_o   = hold_vld_q && !realign;
  assign frame_pos0_o = (bit_q == '0) && (slot_q == '0);
endmodule

// File: rtl/lcs_slot_table.sv
module lcs_slot_table #(
  parameter  int unsigned NET_SLOTS = 192,
  parameter  int unsigned NUM_GRP   = 32,
  parameter  int unsigned FANOUT    = 8,
  localparam int unsigned SEL_W     = $clog2(NUM_GRP),
  localparam int unsigned IDX_W     = $clog2(NET_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_we_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_en_o,
  output logic [SEL_W-1:0] rd_sel_o,
  output logic             conflict_o
);
  logic             en_q  [NET_SLOTS];
  logic [SEL_W-1:0] sel_q [NET_SLOTS];
  logic             conflict_q, in_range, dup, reject, accept;

  // compare the write against the other seven entries of its block
  always_comb begin
    dup      = 1'b0;
    in_range = (32'(wr_addr_i) < NET_SLOTS);
    for (int unsigned i = 0; i < FANOUT; i++) begin
      int unsigned j;
      j = (32'(wr_addr_i) / FANOUT) * FANOUT + i;
      if ((j < NET_SLOTS) && (j != 32'(wr_addr_i))) begin
        if (en_q[IDX_W'(j)] && (sel_q[IDX_W'(j)] == wr_sel_i)) dup = 1'b1;
      end
    end
    reject = wr_we_i && in_range && wr_en_i && dup;
    accept = wr_we_i && in_range && !reject;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conflict_q <= 1'b0;
      for (int k = 0; k < NET_SLOTS; k++) begin
        en_q[k]  <= 1'b0;
        sel_q[k] <= '0;
      end
    end else begin
      conflict_q <= reject;
      if (accept) begin
        en_q[wr_addr_i]  <= wr_en_i;
        sel_q[wr_addr_i] <= wr_sel_i;
      end
    end
  end

  assign rd_en_o    = en_q[rd_idx_i];
  assign rd_sel_o   = sel_q[rd_idx_i];
  assign conflict_o = conflict_q;
endmodule

// File: rtl/lcs_slot_mux.sv
module lcs_slot_mux #(
  parameter  int unsigned NUM_GRP   = 32,
  parameter  int unsigned WORD_W    = 8,
  parameter  int unsigned PCM_SLOTS = 24,
  parameter  int unsigned NET_SLOTS = 192,
  parameter  logic [WORD_W-1:0] IDLE_CODE = 8'hD5,
  localparam int unsigned BIT_W = $clog2(WORD_W),
  localparam int unsigned PSL_W = $clog2(PCM_SLOTS),
  localparam int unsigned SEL_W = $clog2(NUM_GRP),
  localparam int unsigned IDX_W = $clog2(NET_SLOTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [BIT_W-1:0]          cur_bit_i,
  input  logic [PSL_W-1:0]          hold_slot_i,
  input  logic [NUM_GRP*WORD_W-1:0] hold_words_i,
  input  logic                      slot_vld_i,
  input  logic                      rd_en_i,
  input  logic [SEL_W-1:0]          rd_sel_i,
  output logic [IDX_W-1:0]          rd_idx_o,
  output logic                      net_valid_o,
  output logic [IDX_W-1:0]          net_slot_o,
  output logic [WORD_W-1:0]         net_data_o
);
  logic              valid_q;
  logic [IDX_W-1:0]  slot_q;
  logic [WORD_W-1:0] data_q, word;

  // network slot = pcm slot * fanout + bit position inside the following pcm slot
  assign rd_idx_o = IDX_W'({hold_slot_i, cur_bit_i});
  assign word     = hold_words_i[rd_sel_i*WORD_W +: WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
      data_q  <= IDLE_CODE;
    end else begin
      valid_q <= slot_vld_i;
      if (slot_vld_i) begin
        slot_q <= rd_idx_o;
        data_q <= rd_en_i ? word : IDLE_CODE;
      end else begin
        data_q <= IDLE_CODE;
      end
    end
  end

  assign net_valid_o = valid_q;
  assign net_slot_o  = slot_q;
  assign net_data_o  = data_q;
endmodule

// File: rtl/lcs_concentrator.sv
module lcs_concentrator
  import lcs_pkg::*;
#(
  parameter  int unsigned NUM_UNITS    = LCS_UNITS,
  parameter  int unsigned GRP_PER_UNIT = LCS_GRP_PER_UNIT,
  parameter  int unsigned PCM_SLOTS    = LCS_PCM_SLOTS,
  parameter  int unsigned WORD_W       = LCS_WORD_W,
  parameter  logic [WORD_W-1:0] IDLE_CODE = LCS_IDLE,
  localparam int unsigned NUM_GRP   = NUM_UNITS * GRP_PER_UNIT,
  localparam int unsigned FANOUT    = WORD_W,
  localparam int unsigned NET_SLOTS = PCM_SLOTS * FANOUT,
  localparam int unsigned SEL_W     = $clog2(NUM_GRP),
  localparam int unsigned IDX_W     = $clog2(NET_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fsync_i,
  input  logic [NUM_GRP-1:0] pcm_ser_i,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_addr_i,
  input  logic               tbl_en_i,
  input  logic [SEL_W-1:0]   tbl_sel_i,
  output logic               tbl_conflict_o,
  output logic               net_valid_o,
  output logic [IDX_W-1:0]   net_slot_o,
  output logic [WORD_W-1:0]  net_data_o
);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned PSL_W = $clog2(PCM_SLOTS);

  logic [BIT_W-1:0]          cur_bit;
  logic [PSL_W-1:0]          hold_slot;
  logic [NUM_GRP*WORD_W-1:0] hold_words;
  logic                      slot_vld, frame_pos0;
  logic [IDX_W-1:0]          rd_idx;
  logic                      rd_en;
  logic [SEL_W-1:0]          rd_sel;

  lcs_frame_align #(
    .NUM_GRP(NUM_GRP), .WORD_W(WORD_W), .PCM_SLOTS(PCM_SLOTS)
  ) u_align (
    .clk_i, .rst_ni, .fsync_i, .pcm_ser_i,
    .cur_bit_o(cur_bit), .hold_slot_o(hold_slot), .hold_words_o(hold_words),
    .slot_vld_o(slot_vld), .frame_pos0_o(frame_pos0)
  );

  lcs_slot_table #(
    .NET_SLOTS(NET_SLOTS), .NUM_GRP(NUM_GRP), .FANOUT(FANOUT)
  ) u_table (
    .clk_i, .rst_ni,
    .wr_we_i(tbl_we_i), .wr_addr_i(tbl_addr_i), .wr_en_i(tbl_en_i), .wr_sel_i(tbl_sel_i),
    .rd_idx_i(rd_idx), .rd_en_o(rd_en), .rd_sel_o(rd_sel), .conflict_o(tbl_conflict_o)
  );

  lcs_slot_mux #(
    .NUM_GRP(NUM_GRP), .WORD_W(WORD_W), .PCM_SLOTS(PCM_SLOTS),
    .NET_SLOTS(NET_SLOTS), .IDLE_CODE(IDLE_CODE)
  ) u_mux (
    .clk_i, .rst_ni,
    .cur_bit_i(cur_bit), .hold_slot_i(hold_slot), .hold_words_i(hold_words),
    .slot_vld_i(slot_vld), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_idx_o(rd_idx), .net_valid_o, .net_slot_o, .net_data_o
  );
endmodule

// File: rtl/lcs_concentrator_chk.sv
module lcs_concentrator_chk
  import lcs_pkg::*;
#(
  parameter  int unsigned NET_SLOTS = LCS_NET_SLOTS,
  parameter  int unsigned WORD_W    = LCS_WORD_W,
  parameter  logic [WORD_W-1:0] IDLE_CODE = LCS_IDLE,
  localparam int unsigned IDX_W = $clog2(NET_SLOTS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fsync_i,
  input logic              frame_pos0_i,
  input logic              tbl_we_i,
  input logic              tbl_en_i,
  input logic              conflict_i,
  input logic              valid_i,
  input logic [IDX_W-1:0]  slot_i,
  input logic [WORD_W-1:0] data_i,
  input logic              slot_vld_i,
  input logic              rd_en_i
);
  AST_SLOT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (32'(slot_i) < NET_SLOTS)); // R5

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(valid_i)) |->
      (slot_i == (($past(slot_i) == IDX_W'(NET_SLOTS - 1)) ? '0 : $past(slot_i) + 1'b1))); // R5

  AST_FIRST_SLOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> (slot_i == '0)); // R9

  AST_RESYNC_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fsync_i && !frame_pos0_i) |-> !valid_i); // R9

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(slot_vld_i && !rd_en_i) |-> (data_i == IDLE_CODE)); // R4

  AST_CONFLICT_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_i |-> $past(tbl_we_i && tbl_en_i)); // R7
endmodule

bind lcs_concentrator lcs_concentrator_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i), .frame_pos0_i(frame_pos0),
  .tbl_we_i(tbl_we_i), .tbl_en_i(tbl_en_i), .conflict_i(tbl_conflict_o),
  .valid_i(net_valid_o), .slot_i(net_slot_o), .data_i(net_data_o),
  .slot_vld_i(slot_vld), .rd_en_i(rd_en)
);

// File: tb/tb_lcs_concentrator.sv
module tb_lcs_concentrator;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 32;
  localparam int NS = 192;
  localparam logic [7:0] IDLE = 8'hD5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic [NG-1:0] pcm_ser = '0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic       en = 1'b0;
  logic [4:0] sel = '0;
  logic       conflict, nvalid;
  logic [7:0] nslot, ndata;

  int checks = 0;
  int errors = 0;
  int seed = 0;

  logic       model_en  [NS];
  logic [4:0] model_sel [NS];
  logic [7:0] cap  [NS];
  logic       capv [NS];
  logic       lv [1024];
  logic [7:0] ls [1024];
  logic [7:0] ld [1024];

  lcs_concentrator dut (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .pcm_ser_i(pcm_ser),
    .tbl_we_i(we), .tbl_addr_i(addr), .tbl_en_i(en), .tbl_sel_i(sel),
    .tbl_conflict_o(conflict), .net_valid_o(nvalid), .net_slot_o(nslot), .net_data_o(ndata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pcm_word(int g, int k);
    return 8'((g * 37 + k * 13 + seed * 91 + 5) % 256);
  endfunction

  function automatic logic [7:0] exp_out(int n);
    return model_en[n] ? pcm_word(int'(model_sel[n]), n / 8) : IDLE;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(int ncyc, int resync_at);
    int p;
    p = 0;
    for (int n = 0; n < NS; n++) capv[n] = 1'b0;
    for (int j = 0; j < ncyc; j++) begin
      @(negedge clk);
      lv[j] = nvalid; ls[j] = nslot; ld[j] = ndata;
      if (nvalid) begin
        cap[nslot]  = ndata;
        capv[nslot] = 1'b1;
      end
      if (j == resync_at) p = 0;
      fsync = (p == 0);
      for (int g = 0; g < NG; g++) begin
        logic [7:0] w;
        w = pcm_word(g, p / 8);
        pcm_ser[g] = w[7 - (p % 8)];
      end
      p = (p + 1) % NS;
    end
    @(negedge clk);
    fsync = 1'b0;
    pcm_ser = '0;
  endtask

  task automatic check_frame(string req);
    for (int n = 0; n < NS; n++)
      check(capv[n] && (cap[n] == exp_out(n)), req, int'(cap[n]), int'(exp_out(n)));
  endtask

  task automatic wr(int a, bit e, int s, bit exp_c, string req);
    @(negedge clk);
    we = 1'b1; addr = 8'(a); en = e; sel = 5'(s);
    @(negedge clk);
    check(conflict == exp_c, req, int'(conflict), int'(exp_c));
    we = 1'b0;
    @(negedge clk);
    check(conflict == 1'b0, "R7", int'(conflict), 0);
    if (!exp_c && a < NS) begin
      model_en[a]  = e;
      model_sel[a] = 5'(s);
    end
  endtask

  task automatic t_reset;
    for (int n = 0; n < NS; n++) begin
      model_en[n] = 1'b0;
      model_sel[n] = '0;
    end
    repeat (3) @(negedge clk);
    check(nvalid == 1'b0, "R1", int'(nvalid), 0);
    check(conflict == 1'b0, "R1", int'(conflict), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(nvalid == 1'b0, "R1", int'(nvalid), 0);
    seed = 0;
    run(393, -1);
    check_frame("R1");
  endtask

  task automatic t_map;
    bit seq_ok;
    for (int n = 0; n < NS; n++) wr(n, 1'b1, (n % 8) * 4 + (n / 8) % 4, 1'b0, "R7");
    seed = 1;
    run(393, -1);
    check_frame("R2 R3");
    check(lv[9] && ls[9] == 8'd0, "R5", int'(ls[9]), 0);
    check(lv[9] && ld[9] == exp_out(0), "R5", int'(ld[9]), int'(exp_out(0)));
    seq_ok = 1'b1;
    for (int j = 10; j < 393; j++)
      if (!lv[j] || ls[j] != 8'((int'(ls[j-1]) + 1) % NS)) seq_ok = 1'b0;
    check(seq_ok, "R5", int'(seq_ok), 1);
  endtask

  task automatic t_disable;
    wr(5, 1'b0, 20, 1'b0, "R8");
    wr(77, 1'b0, 5, 1'b0, "R8");
    wr(191, 1'b0, 31, 1'b0, "R8");
    seed = 2;
    run(393, -1);
    check_frame("R4");
    check(cap[77] == IDLE, "R4", int'(cap[77]), int'(IDLE));
  endtask

  task automatic t_conflict;
    wr(17, 1'b1, 2, 1'b1, "R6");   // entry 16 holds group 2
    wr(24, 1'b1, 2, 1'b0, "R8");   // other block
    wr(16, 1'b1, 2, 1'b0, "R8");   // same entry rewritten
    wr(0, 1'b1, 20, 1'b0, "R8");   // group 20 held only by disabled entry 5
    wr(2, 1'b1, 20, 1'b1, "R6");   // entry 0 now holds 20
    wr(3, 1'b0, 4, 1'b0, "R8");    // disabled write matching entry 1
    seed = 3;
    run(393, -1);
    check_frame("R3 R6");
    check(cap[17] == pcm_word(6, 2), "R6", int'(cap[17]), int'(pcm_word(6, 2)));
    check(cap[2] == pcm_word(8, 0), "R6", int'(cap[2]), int'(pcm_word(8, 0)));
  endtask

  task automatic t_resync;
    seed = 4;
    run(493, 100);
    for (int j = 101; j <= 108; j++) check(!lv[j], "R9", int'(lv[j]), 0);
    check(lv[109] && ls[109] == 8'd0, "R9", int'(ls[109]), 0);
    check(ld[109] == exp_out(0), "R9", int'(ld[109]), int'(exp_out(0)));
    check_frame("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_map();
    t_disable();
    t_conflict();
    t_resync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule